// File: doc/BRIEF.md
# Dual-Channel Palette Index Port

This block lets a processor reach a 128-byte color palette through two small register pairs. The background channel and the object channel each have their own pair. The background channel owns the lower half of the palette and the object channel owns the upper half. Each pair has two registers:

- **Index register.** It holds a pointer into the channel's half and a flag that turns on auto-increment.
- **Data register.** Writing it stores a byte into the palette at the pointer. Reading it returns the register's held byte: the palette byte loaded when the index was last written, or the byte most recently written. A data write can step the pointer forward, so filling a run of colors needs one index write followed by back-to-back data writes.

A color-mode input gates the whole processor side. When it is low, writes have no effect and every read returns all ones.

A display engine fetches palette bytes through its own request/response stream. That stream works regardless of color mode and of processor traffic.

- **Request side.** A request carries a byte address. It is accepted on a cycle where both `disp_req_valid` and `disp_req_ready` are high.
- **Response side.** The response byte is registered one cycle after acceptance. It stays held, unchanged, for as long as `disp_rsp_ready` is low.
- **Back-pressure.** While a response waits, the request side is not ready. `disp_req_ready` is high exactly when no response is pending or the pending one is being taken in the same cycle.

Top module: `pal_index_port`

## Requirements
- R1: A write to an index register with `cpu_wdata` = v stores v AND 0xBF. Bits 5:0 form the pointer, bit 7 is the auto-increment flag, and bit 6 always reads 0.
- R2: An index write loads the channel's data register with the palette byte at channel base plus the new pointer.
- R3: A data write stores `cpu_wdata` into the palette at channel base plus the current pointer. It also sets the data register to that byte.
- R4: After a data write with the flag set, the pointer becomes (pointer+1) mod 64 and the flag stays set. With the flag clear, the pointer is unchanged.
- R5: Channel 0 (background) uses palette bytes 0 to 63. Channel 1 (object) uses bytes 64 to 127, with base 64.
- R6: While `color_mode` is 0, index and data writes change nothing, and `cpu_rdata` is 0xFF for every select value.
- R7: If the index and data strobes of one channel are both high in the same cycle, only the index write takes effect. The palette is left untouched.
- R8: A display request accepted at a clock edge makes `disp_rsp_valid` go high after that edge, with `disp_rsp_data` equal to the palette byte at `disp_req_addr` before that edge. This works regardless of `color_mode`.
- R9: While `disp_rsp_valid` is high and `disp_rsp_ready` is low, the response stays valid and its data does not change. During that time `disp_req_ready` is low.
- R10: Reset clears both index registers, both data registers and all 128 palette bytes to 0, and drops `disp_rsp_valid`.
- R11: `cpu_rd_sel` selects the register read combinationally. Bit 0 picks index (0) or data (1), and bit 1 picks the channel (0 background, 1 object).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| color_mode | input | 1 | Enables the processor side |
| idx_we | input | 2 | Index write strobe, one per channel |
| dat_we | input | 2 | Data write strobe, one per channel |
| cpu_wdata | input | 8 | Write byte shared by all strobes |
| cpu_rd_sel | input | 2 | Register read select |
| cpu_rdata | output | 8 | Selected register value |
| disp_req_valid | input | 1 | Display fetch request valid |
| disp_req_ready | output | 1 | Display fetch request accepted |
| disp_req_addr | input | 7 | Palette byte address |
| disp_rsp_valid | output | 1 | Fetched byte valid |
| disp_rsp_ready | input | 1 | Consumer takes fetched byte |
| disp_rsp_data | output | 8 | Fetched palette byte |

## Verification
A corrupted pointer or flag becomes visible at the next index read, or through a display fetch one cycle after the next data write lands in the wrong byte. A stale data register is seen on the next data read, since that register is read straight out. A palette fault is visible one cycle after any fetch of the affected address. A response register that slips under back-pressure shows as a changed `disp_rsp_data` on the very next cycle.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t IDX_KEEP = 8'hBF;
  localparam byte_t OFF_VAL  = 8'hFF;
  localparam int    FLAG_BIT = 7;
endpackage

// File: rtl/pal_store.sv
`timescale 1ns/1ps
module pal_store
  import pal_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int PTR_W = 6,
  localparam int DEPTH = NCH << PTR_W,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCH-1:0]              wr_en,
  input  logic [NCH-1:0][PTR_W-1:0]   wr_ptr,
  input  logic [NCH-1:0][7:0]         wr_data,
  input  logic [NCH-1:0][PTR_W-1:0]   lk_ptr,
  output logic [NCH-1:0][7:0]         lk_data,
  input  logic [AW-1:0]               disp_addr,
  output byte_t                       disp_data
);
  byte_t mem [DEPTH];

  function automatic logic [AW-1:0] slot(input int c, input logic [PTR_W-1:0] p);
    return (AW'(c) << PTR_W) | AW'(p);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (wr_en[c]) mem[slot(c, wr_ptr[c])] <= wr_data[c];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_lk
    assign lk_data[g] = mem[slot(g, lk_ptr[g])];
  end

  assign disp_data = mem[disp_addr];
endmodule

// File: rtl/pal_chan.sv
`timescale 1ns/1ps
module pal_chan
  import pal_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             idx_we,
  input  logic             dat_we,
  input  byte_t            wdata,
  input  byte_t            preload,
  output logic [PTR_W-1:0] ptr,
  output logic             inc,
  output byte_t            dat,
  output logic             pal_we
);
  logic idx_hit;

  assign idx_hit = en && idx_we;
  assign pal_we  = en && dat_we && !idx_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      inc <= 1'b0;
      dat <= '0;
    end else if (idx_hit) begin
      ptr <= wdata[PTR_W-1:0];
      inc <= wdata[FLAG_BIT];
      dat <= preload;
    end else if (pal_we) begin
      dat <= wdata;
      if (inc) ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/pal_disp_port.sv
`timescale 1ns/1ps
module pal_disp_port
  import pal_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic [AW-1:0] rd_addr,
  input  byte_t         rd_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output byte_t         rsp_data
);
  logic take;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign rd_addr   = req_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pal_index_port.sv
`timescale 1ns/1ps
module pal_index_port
  import pal_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int PTR_W = 6,
  localparam int DEPTH = NCH << PTR_W,
  localparam int AW    = $clog2(DEPTH),
  localparam int SW    = $clog2(NCH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            color_mode,
  input  logic [NCH-1:0]  idx_we,
  input  logic [NCH-1:0]  dat_we,
  input  logic [7:0]      cpu_wdata,
  input  logic [SW-1:0]   cpu_rd_sel,
  output logic [7:0]      cpu_rdata,
  input  logic            disp_req_valid,
  output logic            disp_req_ready,
  input  logic [AW-1:0]   disp_req_addr,
  output logic            disp_rsp_valid,
  input  logic            disp_rsp_ready,
  output logic [7:0]      disp_rsp_data
);
  logic [NCH-1:0][PTR_W-1:0] ch_ptr;
  logic [NCH-1:0]            ch_inc;
  logic [NCH-1:0][7:0]       ch_dat;
  logic [NCH-1:0]            ch_pwe;
  logic [NCH-1:0][PTR_W-1:0] lk_ptr;
  logic [NCH-1:0][7:0]       lk_data;
  logic [NCH-1:0][7:0]       wr_data;
  logic [NCH-1:0][7:0]       idx_view;
  logic [AW-1:0]             st_addr;
  byte_t                     st_data;
  logic [SW-2:0]             rd_chan;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign lk_ptr[g]  = cpu_wdata[PTR_W-1:0];
    assign wr_data[g] = cpu_wdata;

    pal_chan #(.PTR_W(PTR_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (color_mode),
      .idx_we  (idx_we[g]),
      .dat_we  (dat_we[g]),
      .wdata   (cpu_wdata),
      .preload (lk_data[g]),
      .ptr     (ch_ptr[g]),
      .inc     (ch_inc[g]),
      .dat     (ch_dat[g]),
      .pal_we  (ch_pwe[g])
    );

    always_comb begin
      idx_view[g]               = '0;
      idx_view[g][PTR_W-1:0]    = ch_ptr[g];
      idx_view[g][FLAG_BIT]     = ch_inc[g];
    end
  end

  pal_store #(.NCH(NCH), .PTR_W(PTR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ch_pwe),
    .wr_ptr    (ch_ptr),
    .wr_data   (wr_data),
    .lk_ptr    (lk_ptr),
    .lk_data   (lk_data),
    .disp_addr (st_addr),
    .disp_data (st_data)
  );

  pal_disp_port #(.AW(AW)) u_disp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (disp_req_valid),
    .req_ready (disp_req_ready),
    .req_addr  (disp_req_addr),
    .rd_addr   (st_addr),
    .rd_data   (st_data),
    .rsp_valid (disp_rsp_valid),
    .rsp_ready (disp_rsp_ready),
    .rsp_data  (disp_rsp_data)
  );

  assign rd_chan = cpu_rd_sel[SW-1:1];

  always_comb begin
    cpu_rdata = OFF_VAL;
    if (color_mode && int'(rd_chan) < NCH)
      cpu_rdata = cpu_rd_sel[0] ? ch_dat[rd_chan] : idx_view[rd_chan];
  end
endmodule

// File: rtl/pal_index_port_chk.sv
`timescale 1ns/1ps
module pal_index_port_chk #(
  parameter int NCH   = 2,
  parameter int PTR_W = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      color_mode,
  input logic [NCH-1:0]            idx_we,
  input logic [NCH-1:0]            dat_we,
  input logic [7:0]                cpu_wdata,
  input logic [7:0]                cpu_rdata,
  input logic                      disp_req_valid,
  input logic                      disp_req_ready,
  input logic                      disp_rsp_valid,
  input logic                      disp_rsp_ready,
  input logic [7:0]                disp_rsp_data,
  input logic [NCH-1:0][PTR_W-1:0] ch_ptr,
  input logic [NCH-1:0]            ch_inc
);
  assert_off_reads_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !color_mode |-> cpu_rdata == 8'hFF);

  assert_off_holds_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !color_mode |=> $stable(ch_ptr) && $stable(ch_inc));

  assert_accept_gives_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_req_valid && disp_req_ready |=> disp_rsp_valid);

  assert_rsp_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_rsp_valid && !disp_rsp_ready |=> disp_rsp_valid && $stable(disp_rsp_data));

  assert_stall_blocks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_rsp_valid && !disp_rsp_ready |-> !disp_req_ready);

  for (genvar g = 0; g < NCH; g++) begin : g_c
    logic [PTR_W-1:0] nxt;
    assign nxt = ch_ptr[g] + 1'b1;

    assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      color_mode && idx_we[g] |=>
        ch_ptr[g] == $past(cpu_wdata[PTR_W-1:0]) && ch_inc[g] == $past(cpu_wdata[7]));

    assert_autoinc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      color_mode && dat_we[g] && !idx_we[g] && ch_inc[g] |=>
        ch_ptr[g] == $past(nxt) && ch_inc[g]);

    assert_no_inc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      color_mode && dat_we[g] && !idx_we[g] && !ch_inc[g] |=> $stable(ch_ptr[g]));
  end
endmodule

bind pal_index_port pal_index_port_chk #(.NCH(NCH), .PTR_W(PTR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .color_mode     (color_mode),
  .idx_we         (idx_we),
  .dat_we         (dat_we),
  .cpu_wdata      (cpu_wdata),
  .cpu_rdata      (cpu_rdata),
  .disp_req_valid (disp_req_valid),
  .disp_req_ready (disp_req_ready),
  .disp_rsp_valid (disp_rsp_valid),
  .disp_rsp_ready (disp_rsp_ready),
  .disp_rsp_data  (disp_rsp_data),
  .ch_ptr         (ch_ptr),
  .ch_inc         (ch_inc)
);

// File: tb/sim_pal_index_port.sv
`timescale 1ns/1ps
module sim_pal_index_port;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       color_mode = 1'b1;
  logic [1:0] idx_we = '0;
  logic [1:0] dat_we = '0;
  logic [7:0] cpu_wdata = '0;
  logic [1:0] cpu_rd_sel = '0;
  logic [7:0] cpu_rdata;
  logic       disp_req_valid = 1'b0;
  logic       disp_req_ready;
  logic [6:0] disp_req_addr = '0;
  logic       disp_rsp_valid;
  logic       disp_rsp_ready = 1'b1;
  logic [7:0] disp_rsp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_pal [128];
  logic [5:0] m_ptr [2];
  bit         m_inc [2];
  logic [7:0] m_dat [2];

  always #(CLK_P/2) clk = ~clk;

  pal_index_port u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .color_mode     (color_mode),
    .idx_we         (idx_we),
    .dat_we         (dat_we),
    .cpu_wdata      (cpu_wdata),
    .cpu_rd_sel     (cpu_rd_sel),
    .cpu_rdata      (cpu_rdata),
    .disp_req_valid (disp_req_valid),
    .disp_req_ready (disp_req_ready),
    .disp_req_addr  (disp_req_addr),
    .disp_rsp_valid (disp_rsp_valid),
    .disp_rsp_ready (disp_rsp_ready),
    .disp_rsp_data  (disp_rsp_data)
  );

  function automatic logic [7:0] exp_idx(int ch);
    return {m_inc[ch], 1'b0, m_ptr[ch]};
  endfunction

  function automatic int slot(int ch, logic [5:0] p);
    return ch * 64 + int'(p);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // One write cycle; model follows R1-style masking, preload, autoinc, priority
  task automatic wr(int ch, bit wi, bit wd, logic [7:0] v);
    idx_we[ch] = wi;
    dat_we[ch] = wd;
    cpu_wdata  = v;
    step();
    idx_we = '0;
    dat_we = '0;
    if (color_mode) begin
      if (wi) begin
        m_ptr[ch] = v[5:0];
        m_inc[ch] = v[7];
        m_dat[ch] = m_pal[slot(ch, v[5:0])];
      end else if (wd) begin
        m_pal[slot(ch, m_ptr[ch])] = v;
        m_dat[ch] = v;
        if (m_inc[ch]) m_ptr[ch] = m_ptr[ch] + 6'd1;
      end
    end
  endtask

  task automatic chk_reg(int ch, bit data, string req);
    logic [7:0] e;
    cpu_rd_sel = {ch[0], data};
    #1;
    e = !color_mode ? 8'hFF : (data ? m_dat[ch] : exp_idx(ch));
    check(cpu_rdata == e, req, cpu_rdata, e);
  endtask

  task automatic disp_chk(int a, string req);
    disp_rsp_ready = 1'b1;
    disp_req_valid = 1'b1;
    disp_req_addr  = 7'(a);
    step();
    disp_req_valid = 1'b0;
    check(disp_rsp_valid == 1'b1, req, disp_rsp_valid, 1);
    check(disp_rsp_data == m_pal[a], req, disp_rsp_data, m_pal[a]);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    for (int i = 0; i < 128; i++) m_pal[i] = '0;
    for (int c = 0; c < 2; c++) begin
      m_ptr[c] = '0; m_inc[c] = 1'b0; m_dat[c] = '0;
    end
    void'($urandom(32'd4242));
    #(CLK_P * 3);
    check(disp_rsp_valid == 1'b0, "R10", disp_rsp_valid, 0);
    rst_n = 1'b1;
    step();

    // R10 reset state, R11 select decoding
    for (int c = 0; c < 2; c++) begin
      chk_reg(c, 0, "R10");
      chk_reg(c, 1, "R11");
    end
    disp_chk(0, "R10");
    disp_chk(127, "R10");

    // R1 masking of bit 6
    wr(0, 1, 0, 8'hFF);
    chk_reg(0, 0, "R1");
    // R3, R4 wrap from 63 to 0 with flag kept
    wr(0, 1, 0, 8'hBF);
    wr(0, 0, 1, 8'h3C);
    chk_reg(0, 0, "R4");
    chk_reg(0, 1, "R3");
    disp_chk(63, "R3");
    // R4 no-flag pointer hold
    wr(1, 1, 0, 8'h05);
    wr(1, 0, 1, 8'h5A);
    chk_reg(1, 0, "R4");
    // R5 object base is 64
    disp_chk(69, "R5");
    disp_chk(5, "R5");
    // R2 preload on index write
    wr(0, 1, 0, 8'h3F);
    chk_reg(0, 1, "R2");
    wr(1, 1, 0, 8'h85);
    chk_reg(1, 1, "R2");
    // R7 index beats data in same cycle
    wr(1, 1, 1, 8'h8A);
    chk_reg(1, 0, "R7");
    chk_reg(1, 1, "R7");
    disp_chk(64 + 5, "R7");
    disp_chk(64 + 10, "R7");
    // R6 color mode off
    color_mode = 1'b0;
    wr(0, 1, 0, 8'h11);
    wr(0, 0, 1, 8'h77);
    chk_reg(0, 0, "R6");
    chk_reg(1, 1, "R6");
    // R8 display path works with color mode off
    disp_chk(63, "R8");
    disp_chk(0, "R8");
    color_mode = 1'b1;
    chk_reg(0, 0, "R6");
    chk_reg(0, 1, "R6");

    // R9 back-pressure
    disp_rsp_ready = 1'b0;
    disp_req_valid = 1'b1;
    disp_req_addr  = 7'd74;
    step();
    disp_req_valid = 1'b0;
    held = m_pal[74];
    check(disp_rsp_valid == 1'b1, "R9", disp_rsp_valid, 1);
    check(disp_req_ready == 1'b0, "R9", disp_req_ready, 0);
    wr(1, 1, 0, 8'h0A);
    wr(1, 0, 1, 8'hC3);
    check(disp_rsp_valid == 1'b1, "R9", disp_rsp_valid, 1);
    check(disp_rsp_data == held, "R9", disp_rsp_data, held);
    disp_rsp_ready = 1'b1;
    #1;
    check(disp_req_ready == 1'b1, "R9", disp_req_ready, 1);
    step();
    check(disp_rsp_valid == 1'b0, "R9", disp_rsp_valid, 0);
    disp_chk(74, "R8");

    // Constrained random mix
    for (int n = 0; n < 1500; n++) begin
      int op = $urandom_range(0, 11);
      int ch = $urandom_range(0, 1);
      logic [7:0] v = 8'($urandom);
      case (op)
        0, 1:    wr(ch, 1, 0, v);
        2, 3, 4: wr(ch, 0, 1, v);
        5:       wr(ch, 1, 1, v);
        6, 7:    chk_reg(ch, 1'($urandom), "R11");
        8, 9:    disp_chk($urandom_range(0, 127), "R8");
        10:      begin
                   if ($urandom_range(0, 3) == 0) color_mode = ~color_mode;
                   chk_reg(ch, 0, "R6");
                 end
        default: begin
                   wr(ch, 0, 1, v);
                   chk_reg(ch, 0, "R4");
                 end
      endcase
    end
    color_mode = 1'b1;
    for (int a = 0; a < 128; a++) disp_chk(a, "R3");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule